// File: doc/BRIEF.md
# Multiplexed LCD Frame Timing Generator

This block produces the frame timing and the per-pin drive-level codes for a liquid crystal panel with four common lines and thirty-two segment lines. The input clock is divided into a system clock. Each common line is then made the active row in turn for a fixed number of system clocks, and the drive polarity is reversed on every frame so that no pixel sees a net DC voltage. For every common and segment pin the block outputs a two-bit level code. An external resistor ladder turns that code into a voltage.

Duty (static, or two-, three- or four-way time division) and bias (static, one-half or one-third) are inputs, and they may change while the block is running. Segment on/off bits come from an external display latch, one bit per segment per common row.

Several devices can share one open-drain sync line. While a device is held in reset it pulses the line at the input clock divided by the prescale ratio, and the other devices on the line lock their prescalers to it. Once a device runs, it pulls the line low for one input clock at the start of each even-polarity frame. A device that sees a falling edge on the line at any other moment restarts its frame so that it lines up with the device that pulled.

Top module: `lcd_mux_timing`

## Requirements
- R1: `duty_sel` gives the index of the last common in use (0 = static, 1 = two-way, 2 = three-way, 3 = four-way). `cur_phase` steps 0, 1, ... up to `duty_sel` and then returns to 0. In static duty it stays at 0.
- R2: Every common phase lasts PHASE_LEN system clocks. With the default values this is 4 x 4 = 16 input clocks.
- R3: `frame_pol` toggles exactly when the phase wraps from `duty_sel` back to 0. In static duty this happens once per phase.
- R4: The common whose index equals `cur_phase` gets the select level. Every other common, including commons beyond `duty_sel`, gets the non-select level. Common c is driven on `com_lvl[2c+1:2c]`.
- R5: Segment s gets the select level when bit `seg_bits[cur_phase*32+s]` is 1, and the non-select level otherwise. It is driven on `seg_lvl[2s+1:2s]`.
- R6: The level codes are 0 = VSS, 1 = VLC3, 2 = VLC2 and 3 = VLC1. `bias_sel` is 0 for static, 1 for one-half and 2 or 3 for one-third. With polarity 0, the (common select, common non-select, segment select, segment non-select) codes are: static (3,3,0,3), one-half (3,2,0,3), one-third (3,1,0,2). With polarity 1 they are: static (0,0,3,0), one-half (0,2,3,0), one-third (0,2,3,1).
- R7: While `rst_n` is low, `sync_pull` is a square wave at the input clock divided by 4: high for 2 input clocks, then low for 2.
- R8: Reset leaves `cur_phase` at 0 and `frame_pol` at 0. While running, `sync_pull` goes high for exactly one input clock, and only at the first input clock of a phase-0, polarity-0 frame.
- R9: A falling edge on `sync_in` that does not coincide with the device's own frame origin restarts the frame on the next clock (phase 0, polarity 0). Two devices sharing the line therefore end up with the same phase, polarity and common codes.
- R10: A change of bias takes effect on the level codes at once. A change of duty takes effect at the next phase step, with no reset needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (fCL) |
| rst_n | input | 1 | Active-low reset |
| duty_sel | input | 2 | Index of last common in use |
| bias_sel | input | 2 | Bias select (0 static, 1 half, 2/3 third) |
| seg_bits | input | 128 | Display latch, bit c*32+s = segment s on common c |
| sync_in | input | 1 | Sampled level of the shared open-drain sync line |
| sync_pull | output | 1 | 1 = pull the sync line low |
| cur_phase | output | 2 | Index of the active common |
| frame_pol | output | 1 | Current drive polarity |
| com_lvl | output | 8 | Level code per common, 2 bits each |
| seg_lvl | output | 64 | Level code per segment, 2 bits each |

## Verification
Phase sequencing is run at each of the four duties. This separates an off-by-one in the wrap point, a wrong phase length and a polarity flip on the wrong step. The level map is driven with all-ones, all-zeros, a checkerboard and a diagonal pattern that differs per common row, under every bias code and both polarities. All-ones and all-zeros catch swapped select and non-select codes. The checkerboard catches segment index errors, and the diagonal catches the wrong common row being read from the latch. The sync line is exercised three ways: on its own during reset, on its own while running, and wired to a second device released late. This shows the reset clock output, the single-clock frame pulse and the restart alignment.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  // Bias encodings on bias_sel; the value 3 behaves as one-third.
  localparam logic [1:0] BIAS_STATIC = 2'd0;
  localparam logic [1:0] BIAS_HALF   = 2'd1;

  // Level code for one pin. Positive polarity is built first, then mirrored.
  // With one-half bias the two middle codes merge onto code 2.
  function automatic logic [1:0] drive_code(input logic [1:0] bias,
                                            input logic       pol,
                                            input logic       is_com,
                                            input logic       sel);
    logic [1:0] c;
    if (is_com)
      c = sel ? 2'd3 : ((bias == BIAS_STATIC) ? 2'd3 :
                        (bias == BIAS_HALF)   ? 2'd2 : 2'd1);
    else
      c = sel ? 2'd0 : ((bias == BIAS_STATIC) ? 2'd3 :
                        (bias == BIAS_HALF)   ? 2'd3 : 2'd2);
    if (pol) c = ~c;
    if (bias == BIAS_HALF && c == 2'd1) c = 2'd2;
    return c;
  endfunction

endpackage

// File: rtl/lcd_clk_div.sv
module lcd_clk_div #(
  parameter int DIV = 4,
  localparam int PW = $clog2(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  output logic [PW-1:0] pres,
  output logic          tick,
  output logic          low_half
);

  // The prescaler keeps counting through reset, so the sync line can carry
  // a divided clock while the device is held in reset.
  always_ff @(posedge clk) begin
    if (load)      pres <= PW'(1);
    else if (tick) pres <= '0;
    else           pres <= pres + PW'(1);
  end

  assign tick     = (pres == PW'(DIV - 1));
  assign low_half = (pres < PW'(DIV / 2));

  generate
    if (DIV > 2) begin : g_spacing
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("system clock enable on consecutive input clocks");
    end
  endgenerate

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int NCOM      = 4,
  parameter int PHASE_LEN = 4,
  localparam int CW = $clog2(NCOM),
  localparam int SW = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic [CW-1:0] duty,
  output logic [CW-1:0] phase,
  output logic          pol,
  output logic          at_start
);

  logic [SW-1:0] slot;
  logic          phase_step;
  logic          frame_end;

  function automatic logic [CW-1:0] next_phase(input logic [CW-1:0] p,
                                               input logic [CW-1:0] last);
    return (p >= last) ? '0 : p + CW'(1);
  endfunction

  assign phase_step = tick && (slot == SW'(PHASE_LEN - 1));
  assign frame_end  = phase_step && (phase >= duty);
  assign at_start   = (slot == '0) && (phase == '0) && !pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '0;
      phase <= '0;
      pol   <= 1'b0;
    end else if (restart) begin
      slot  <= '0;
      phase <= '0;
      pol   <= 1'b0;
    end else if (tick) begin
      if (phase_step) begin
        slot  <= '0;
        phase <= next_phase(phase, duty);
        if (frame_end) pol <= ~pol;
      end else begin
        slot <= slot + SW'(1);
      end
    end
  end

  a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_step && !restart) |=> (phase == '0 || phase == $past(phase) + CW'(1)))
    else $error("phase did not step to the next common or wrap");

  a_r3_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !restart) |=> $stable(pol))
    else $error("polarity changed away from a frame end");

  a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(slot))
    else $error("slot moved without a system clock enable");

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_mux_pkg::*;
#(
  parameter int NCOM = 4,
  parameter int NSEG = 32,
  localparam int CW = $clog2(NCOM)
) (
  input  logic [CW-1:0]        phase,
  input  logic                 pol,
  input  logic [CW-1:0]        duty,
  input  logic [1:0]           bias,
  input  logic [NCOM*NSEG-1:0] seg_bits,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl,
  output logic [NCOM-1:0]      com_sel
);

  logic            row_live;
  logic [NSEG-1:0] row;

  // Rows beyond the duty are never active (covers a duty cut mid-frame).
  assign row_live = (phase <= duty);
  assign row      = seg_bits[phase*NSEG +: NSEG];

  generate
    for (genvar c = 0; c < NCOM; c++) begin : g_com
      assign com_sel[c]       = row_live && (phase == CW'(c));
      assign com_lvl[2*c +: 2] = drive_code(bias, pol, 1'b1, com_sel[c]);
    end
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
      assign seg_lvl[2*s +: 2] = drive_code(bias, pol, 1'b0, row_live && row[s]);
    end
  endgenerate

endmodule

// File: rtl/lcd_mux_timing.sv
module lcd_mux_timing
  import lcd_mux_pkg::*;
#(
  parameter int NCOM      = 4,
  parameter int NSEG      = 32,
  parameter int CLK_DIV   = 4,
  parameter int PHASE_LEN = 4,
  localparam int CW = $clog2(NCOM),
  localparam int PW = $clog2(CLK_DIV)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        duty_sel,
  input  logic [1:0]           bias_sel,
  input  logic [NCOM*NSEG-1:0] seg_bits,
  input  logic                 sync_in,
  output logic                 sync_pull,
  output logic [CW-1:0]        cur_phase,
  output logic                 frame_pol,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);

  logic [PW-1:0]   pres;
  logic            tick;
  logic            low_half;
  logic            sync_q;
  logic            line_fall;
  logic            realign;
  logic            resync;
  logic            at_start;
  logic            frame_origin;
  logic [NCOM-1:0] com_sel;

  // Line history keeps running through reset so prescalers align there too.
  always_ff @(posedge clk) sync_q <= sync_in;

  assign line_fall    = sync_q && !sync_in;
  assign frame_origin = at_start && (pres == '0);
  assign realign      = line_fall && (rst_n ? !frame_origin : (pres != '0));
  assign resync       = realign && rst_n;
  assign sync_pull    = rst_n ? frame_origin : low_half;

  lcd_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (realign),
    .pres     (pres),
    .tick     (tick),
    .low_half (low_half)
  );

  lcd_phase_seq #(.NCOM(NCOM), .PHASE_LEN(PHASE_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (resync),
    .duty     (duty_sel),
    .phase    (cur_phase),
    .pol      (frame_pol),
    .at_start (at_start)
  );

  lcd_level_map #(.NCOM(NCOM), .NSEG(NSEG)) u_map (
    .phase    (cur_phase),
    .pol      (frame_pol),
    .duty     (duty_sel),
    .bias     (bias_sel),
    .seg_bits (seg_bits),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl),
    .com_sel  (com_sel)
  );

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pull |=> !sync_pull)
    else $error("frame sync pulse wider than one clock");

  a_r9_restart_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (at_start && pres == PW'(1)))
    else $error("restart did not land on the frame origin");

  a_r4_one_common: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel))
    else $error("more than one common at select level");

endmodule

// File: tb/test_lcd_mux_timing.sv
module test_lcd_mux_timing;

  localparam int CLK_PERIOD = 10;
  localparam int PH_CLKS    = 16;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rst_nb = 1'b0;
  logic         link = 1'b0;
  logic [1:0]   duty_sel = 2'd3;
  logic [1:0]   bias_sel = 2'd2;
  logic [127:0] seg_bits = '0;
  logic         pull_a, pull_b;
  logic         line_a, line_b;
  logic [1:0]   phase_a, phase_b;
  logic         pol_a, pol_b;
  logic [7:0]   com_a, com_b;
  logic [63:0]  seg_a, seg_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line_a = ~(pull_a | (link & pull_b));
  assign line_b = ~(pull_b | (link & pull_a));

  lcd_mux_timing i_lcd_mux_timing (
    .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .bias_sel(bias_sel),
    .seg_bits(seg_bits), .sync_in(line_a), .sync_pull(pull_a),
    .cur_phase(phase_a), .frame_pol(pol_a), .com_lvl(com_a), .seg_lvl(seg_a));

  lcd_mux_timing i_lcd_mux_timing_b (
    .clk(clk), .rst_n(rst_nb), .duty_sel(duty_sel), .bias_sel(bias_sel),
    .seg_bits(seg_bits), .sync_in(line_b), .sync_pull(pull_b),
    .cur_phase(phase_b), .frame_pol(pol_b), .com_lvl(com_b), .seg_lvl(seg_b));

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Level table restated from the requirement (R6)
  function automatic logic [1:0] m_code(input logic [1:0] b, input logic p,
                                        input logic is_com, input logic sel);
    logic [1:0] bb;
    bb = (b == 2'd3) ? 2'd2 : b;
    case ({bb, p, is_com, sel})
      5'b00_0_1_1: return 2'd3;  5'b00_0_1_0: return 2'd3;
      5'b00_0_0_1: return 2'd0;  5'b00_0_0_0: return 2'd3;
      5'b01_0_1_1: return 2'd3;  5'b01_0_1_0: return 2'd2;
      5'b01_0_0_1: return 2'd0;  5'b01_0_0_0: return 2'd3;
      5'b10_0_1_1: return 2'd3;  5'b10_0_1_0: return 2'd1;
      5'b10_0_0_1: return 2'd0;  5'b10_0_0_0: return 2'd2;
      5'b00_1_1_1: return 2'd0;  5'b00_1_1_0: return 2'd0;
      5'b00_1_0_1: return 2'd3;  5'b00_1_0_0: return 2'd0;
      5'b01_1_1_1: return 2'd0;  5'b01_1_1_0: return 2'd2;
      5'b01_1_0_1: return 2'd3;  5'b01_1_0_0: return 2'd0;
      5'b10_1_1_1: return 2'd0;  5'b10_1_1_0: return 2'd2;
      5'b10_1_0_1: return 2'd3;  5'b10_1_0_0: return 2'd1;
      default:     return 2'd0;
    endcase
  endfunction

  task automatic t_reset;
    logic h[12];
    repeat (6) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      h[k] = pull_a;
      @(negedge clk);
    end
    for (int k = 4; k < 12; k++) begin
      check(h[k] == h[k-4], "R7 period", 64'(h[k]), 64'(h[k-4]));
      check(h[k] != h[k-2], "R7 half", 64'(h[k]), 64'(!h[k-2]));
    end
    check(phase_a == 2'd0, "R8 reset phase", 64'(phase_a), 0);
    check(pol_a == 1'b0, "R8 reset pol", 64'(pol_a), 0);
    check(com_a == 8'b01_01_01_11, "R4 reset commons", 64'(com_a), 64'h57);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_a == 2'd0 && pol_a == 1'b0, "R8 after release", 64'({pol_a, phase_a}), 0);
  endtask

  task automatic t_sequence(input logic [1:0] d);
    int cnt, events, guard;
    logic [1:0] pp;
    logic pq;
    duty_sel = d;
    pq = pol_a; guard = 0;
    while (pol_a == pq && guard < 400) begin @(negedge clk); guard++; end
    pp = phase_a; pq = pol_a; cnt = 0; events = 0;
    while (events < 3 * (int'(d) + 1) && guard < 2000) begin
      @(negedge clk); cnt++; guard++;
      if (phase_a != pp || pol_a != pq) begin
        check(cnt == PH_CLKS, "R2 phase length", 64'(cnt), PH_CLKS);
        check(phase_a == ((pp >= d) ? 2'd0 : 2'(pp + 2'd1)), "R1 next phase",
              64'(phase_a), 64'((pp >= d) ? 2'd0 : 2'(pp + 2'd1)));
        check((pol_a != pq) == (pp >= d), "R3 flip at wrap",
              64'(pol_a != pq), 64'(pp >= d));
        pp = phase_a; pq = pol_a; cnt = 0; events++;
      end
    end
    check(events == 3 * (int'(d) + 1), "R1 event count", 64'(events), 64'(3 * (int'(d) + 1)));
  endtask

  task automatic t_levels(input logic [1:0] b, input logic [127:0] pat);
    logic [7:0]  ec;
    logic [63:0] es;
    bias_sel = b;
    seg_bits = pat;
    @(negedge clk);
    check(com_a[1:0] == m_code(b, pol_a, 1'b1, phase_a == 2'd0 && duty_sel != 2'd9),
          "R10 bias at once", 64'(com_a[1:0]), 64'(m_code(b, pol_a, 1'b1, phase_a == 2'd0)));
    for (int n = 0; n < 72; n++) begin
      for (int c = 0; c < 4; c++)
        ec[2*c +: 2] = m_code(b, pol_a, 1'b1, (phase_a == 2'(c)) && (phase_a <= duty_sel));
      for (int s = 0; s < 32; s++)
        es[2*s +: 2] = m_code(b, pol_a, 1'b0,
                              (phase_a <= duty_sel) && pat[int'(phase_a) * 32 + s]);
      check(com_a == ec, "R4 common codes", 64'(com_a), 64'(ec));
      check(seg_a == es, "R5 segment codes", seg_a, es);
      @(negedge clk);
    end
  endtask

  task automatic t_unused;
    duty_sel = 2'd1;
    bias_sel = 2'd2;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 64; n++) begin
      check(com_a[7:4] == (pol_a ? 4'b1010 : 4'b0101), "R4 unused commons",
            64'(com_a[7:4]), 64'(pol_a ? 4'b1010 : 4'b0101));
      check(phase_a <= 2'd1, "R1 two-way bound", 64'(phase_a), 1);
      @(negedge clk);
    end
  endtask

  task automatic t_sync_pulse;
    int pulses = 0;
    logic prev = 1'b0;
    duty_sel = 2'd3;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (prev) check(!pull_a, "R8 pulse width", 64'(pull_a), 0);
      if (pull_a) begin
        pulses++;
        check(phase_a == 2'd0 && pol_a == 1'b0, "R8 pulse at origin",
              64'({pol_a, phase_a}), 0);
      end
      prev = pull_a;
    end
    check(pulses >= 2, "R8 pulse count", 64'(pulses), 2);
  endtask

  task automatic t_align;
    duty_sel = 2'd3;
    bias_sel = 2'd2;
    link = 1'b1;
    repeat (37) @(negedge clk);
    rst_nb = 1'b1;
    repeat (400) @(negedge clk);
    for (int n = 0; n < 128; n++) begin
      check(phase_a == phase_b, "R9 phase aligned", 64'(phase_a), 64'(phase_b));
      check(pol_a == pol_b, "R9 pol aligned", 64'(pol_a), 64'(pol_b));
      check(com_a == com_b, "R9 commons aligned", 64'(com_a), 64'(com_b));
      @(negedge clk);
    end
  endtask

  initial begin
    logic [127:0] diag;
    logic [127:0] checker_pat;
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 32; s++)
        diag[c*32 + s] = ((c + s) % 3 == 0);
    checker_pat = {64{2'b01}};
    t_reset();
    t_sequence(2'd3);
    t_sequence(2'd2);
    t_sequence(2'd1);
    t_sequence(2'd0);
    duty_sel = 2'd3;
    t_levels(2'd2, '1);
    t_levels(2'd1, checker_pat);
    t_levels(2'd0, diag);
    t_levels(2'd2, '0);
    t_levels(2'd3, diag);
    duty_sel = 2'd2;
    t_levels(2'd1, diag);
    t_unused();
    t_sync_pulse();
    t_align();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule